// File: doc/BRIEF.md
# UART Register and Interrupt Block

This block is the software-visible register file of a UART peripheral. A 32-bit single-cycle bus reads and writes a 1 KiB window of word registers: interrupt state, interrupt enable, interrupt test, control, status, receive data, transmit data, FIFO control and FIFO status. Shifters and FIFO storage sit outside. They are reached through ports: a four-bit vector of hardware set pulses, a receive-byte strobe, the transmit FIFO fill level, and a push strobe with its byte for the transmit FIFO.

Four level interrupt lines leave the block, one per source. A line is high while its state bit and its enable bit are both set. Software clears state bits by writing ones to the state register and forces them through the test register. When receive is enabled, an arriving byte lowers the receive-idle and receive-empty status flags. A later read of the receive data register raises them again.

Top module: `uart_csr_block`

## Requirements
- R1: After reset, interrupt state, interrupt enable, control, FIFO control and receive data read 0, all interrupt lines are low, and status (byte offset 0x10) reads 0x0000003C.
- R2: Interrupt bit k (0 TX watermark, 1 RX watermark, 2 TX empty, 3 RX overflow) drives its line high exactly while state bit k and enable bit k (offset 0x04) are both 1. The line follows a register write on the next clock.
- R3: A write to interrupt state (offset 0x00) clears each bit written as 1 and keeps every other bit.
- R4: A write to interrupt test (offset 0x08) ORs the written low four bits into interrupt state.
- R5: A 1 on bit k of the hardware set vector sets state bit k. This wins over a software clear of that bit in the same cycle.
- R6: A receive-byte strobe while control bit 1 (RX enable, control at offset 0x0C) is 1 stores the byte in receive data (offset 0x14) and clears status bits 4 (RX idle) and 5 (RX empty). While that bit is 0, the strobe changes nothing.
- R7: A read of receive data while RX enable is 1 sets status bits 4 and 5. While RX enable is 0, the read leaves status unchanged.
- R8: Writes to status, receive data and FIFO status are ignored. Transmit data (offset 0x18) and interrupt test read as 0.
- R9: Reads of unmapped or non-word-aligned addresses return 0, and writes to them change no register.
- R10: FIFO status (offset 0x20) reads the transmit FIFO fill level in its low bits and 0 above them.
- R11: Control and FIFO control (offset 0x1C) store all 32 written bits, read them back, and drive them on their output ports.
- R12: A write to transmit data raises the push strobe for that cycle, carrying the low byte of the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| hw_set | input | 4 | Hardware interrupt set pulses, bit k per source |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_level | input | TXLVL_W | Transmit FIFO fill level |
| tx_push | output | 1 | Push strobe to transmit FIFO |
| tx_byte | output | 8 | Byte to push |
| ctrl_o | output | 32 | Control register contents |
| fifo_ctrl_o | output | 32 | FIFO control register contents |
| irq_tx_wm | output | 1 | TX watermark interrupt |
| irq_rx_wm | output | 1 | RX watermark interrupt |
| irq_tx_empty | output | 1 | TX empty interrupt |
| irq_rx_overflow | output | 1 | RX overflow interrupt |

## Verification
The hardest case to reach is a hardware set pulse and a software clear that hit the same state bit in the same clock. The bench places both on one edge: a write of all ones to the state register and a set pulse on one bit. It then reads back only that bit. The receive-status handshake comes next in difficulty. The bench takes it through arrival, re-arm on read, arrival while disabled, and a read while disabled. It checks status and receive data at the ports between every step.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
  localparam int CSR_W     = 32;
  localparam int N_IRQ     = 4;
  localparam int BYTE_W    = 8;
  localparam int ST_RX_IDLE  = 4;
  localparam int ST_RX_EMPTY = 5;
  localparam int CTRL_RX_EN  = 1;
  localparam logic [CSR_W-1:0] STATUS_RST = 32'h0000_003C;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ISTATE, SEL_IENABLE, SEL_ITEST, SEL_CTRL,
    SEL_STATUS, SEL_RDATA, SEL_WDATA, SEL_FCTRL, SEL_FSTATUS
  } csr_sel_e;

  // Word decode of a byte address; misaligned accesses hit nothing.
  function automatic csr_sel_e csr_decode(input logic [CSR_W-1:0] a);
    if (a[1:0] != 2'b00) return SEL_NONE;
    case (a)
      32'h00: return SEL_ISTATE;
      32'h04: return SEL_IENABLE;
      32'h08: return SEL_ITEST;
      32'h0C: return SEL_CTRL;
      32'h10: return SEL_STATUS;
      32'h14: return SEL_RDATA;
      32'h18: return SEL_WDATA;
      32'h1C: return SEL_FCTRL;
      32'h20: return SEL_FSTATUS;
      default: return SEL_NONE;
    endcase
  endfunction

  // Next interrupt state: hardware set and test force bits, clear loses.
  function automatic logic [N_IRQ-1:0] irq_next(
    input logic [N_IRQ-1:0] cur, input logic [N_IRQ-1:0] clr,
    input logic [N_IRQ-1:0] tst, input logic [N_IRQ-1:0] hw);
    return (cur & ~clr) | tst | hw;
  endfunction
endpackage

// File: rtl/uart_irq_bank.sv
module uart_irq_bank
  import uart_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_state,
  input  logic             wr_enable,
  input  logic             wr_test,
  input  logic [N_IRQ-1:0] wdata,
  input  logic [N_IRQ-1:0] hw_set,
  output logic [N_IRQ-1:0] state_q,
  output logic [N_IRQ-1:0] enable_q,
  output logic [N_IRQ-1:0] irq_o
);
  logic [N_IRQ-1:0] clr_mask, tst_mask;

  assign clr_mask = wr_state ? wdata : '0;
  assign tst_mask = wr_test  ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= '0;
      enable_q <= '0;
    end else begin
      state_q <= irq_next(state_q, clr_mask, tst_mask, hw_set);
      if (wr_enable) enable_q <= wdata;
    end
  end

  for (genvar k = 0; k < N_IRQ; k++) begin : g_line
    assign irq_o[k] = state_q[k] & enable_q[k];
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rdata_rd,
  output logic              rx_accept,
  output logic              rd_rearm,
  output logic [CSR_W-1:0]  status_q,
  output logic [BYTE_W-1:0] rdata_q
);
  assign rx_accept = rx_valid & rx_en;
  assign rd_rearm  = rdata_rd & rx_en & ~rx_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= STATUS_RST;
      rdata_q  <= '0;
    end else if (rx_accept) begin
      rdata_q                <= rx_byte;
      status_q[ST_RX_IDLE]   <= 1'b0;
      status_q[ST_RX_EMPTY]  <= 1'b0;
    end else if (rd_rearm) begin
      status_q[ST_RX_IDLE]   <= 1'b1;
      status_q[ST_RX_EMPTY]  <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_csr_rmux.sv
module uart_csr_rmux
  import uart_csr_pkg::*;
#(
  parameter int TXLVL_W = 5
) (
  input  csr_sel_e           sel,
  input  logic               rd_en,
  input  logic [N_IRQ-1:0]   istate,
  input  logic [N_IRQ-1:0]   ienable,
  input  logic [CSR_W-1:0]   ctrl,
  input  logic [CSR_W-1:0]   status,
  input  logic [BYTE_W-1:0]  rdata,
  input  logic [CSR_W-1:0]   fctrl,
  input  logic [TXLVL_W-1:0] tx_level,
  output logic [CSR_W-1:0]   dout
);
  localparam int IRQ_PAD = CSR_W - N_IRQ;
  localparam int BYTE_PAD = CSR_W - BYTE_W;
  localparam int LVL_PAD = CSR_W - TXLVL_W;

  always_comb begin
    dout = '0;
    if (rd_en) begin
      case (sel)
        SEL_ISTATE:  dout = {{IRQ_PAD{1'b0}}, istate};
        SEL_IENABLE: dout = {{IRQ_PAD{1'b0}}, ienable};
        SEL_CTRL:    dout = ctrl;
        SEL_STATUS:  dout = status;
        SEL_RDATA:   dout = {{BYTE_PAD{1'b0}}, rdata};
        SEL_FCTRL:   dout = fctrl;
        SEL_FSTATUS: dout = {{LVL_PAD{1'b0}}, tx_level};
        default:     dout = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_csr_block.sv
module uart_csr_block
  import uart_csr_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int TXLVL_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [3:0]         hw_set,
  input  logic               rx_valid,
  input  logic [7:0]         rx_byte,
  input  logic [TXLVL_W-1:0] tx_level,
  output logic               tx_push,
  output logic [7:0]         tx_byte,
  output logic [31:0]        ctrl_o,
  output logic [31:0]        fifo_ctrl_o,
  output logic               irq_tx_wm,
  output logic               irq_rx_wm,
  output logic               irq_tx_empty,
  output logic               irq_rx_overflow
);
  localparam int ADDR_PAD = CSR_W - ADDR_W;

  csr_sel_e         sel;
  logic             wr_hit, rd_hit;
  logic             wr_istate, wr_ienable, wr_itest, wr_ctrl, wr_fctrl;
  logic             wr_status, rd_rdata, rx_en, rx_accept, rd_rearm;
  logic [N_IRQ-1:0] istate_q, ienable_q, irq_vec;
  logic [CSR_W-1:0] ctrl_q, fctrl_q, status_q;
  logic [BYTE_W-1:0] rdata_q;

  assign sel    = csr_decode({{ADDR_PAD{1'b0}}, bus_addr});
  assign wr_hit = bus_valid &  bus_write;
  assign rd_hit = bus_valid & ~bus_write;

  assign wr_istate  = wr_hit && sel == SEL_ISTATE;
  assign wr_ienable = wr_hit && sel == SEL_IENABLE;
  assign wr_itest   = wr_hit && sel == SEL_ITEST;
  assign wr_ctrl    = wr_hit && sel == SEL_CTRL;
  assign wr_fctrl   = wr_hit && sel == SEL_FCTRL;
  assign wr_status  = wr_hit && sel == SEL_STATUS;
  assign rd_rdata   = rd_hit && sel == SEL_RDATA;
  assign tx_push    = wr_hit && sel == SEL_WDATA;
  assign tx_byte    = bus_wdata[BYTE_W-1:0];
  assign rx_en      = ctrl_q[CTRL_RX_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      fctrl_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= bus_wdata;
      if (wr_fctrl) fctrl_q <= bus_wdata;
    end
  end

  uart_irq_bank u_irq (
    .clk(clk), .rst_n(rst_n),
    .wr_state(wr_istate), .wr_enable(wr_ienable), .wr_test(wr_itest),
    .wdata(bus_wdata[N_IRQ-1:0]), .hw_set(hw_set),
    .state_q(istate_q), .enable_q(ienable_q), .irq_o(irq_vec)
  );

  uart_rx_status u_rxs (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rdata_rd(rd_rdata),
    .rx_accept(rx_accept), .rd_rearm(rd_rearm),
    .status_q(status_q), .rdata_q(rdata_q)
  );

  uart_csr_rmux #(.TXLVL_W(TXLVL_W)) u_rmux (
    .sel(sel), .rd_en(rd_hit), .istate(istate_q), .ienable(ienable_q),
    .ctrl(ctrl_q), .status(status_q), .rdata(rdata_q), .fctrl(fctrl_q),
    .tx_level(tx_level), .dout(bus_rdata)
  );

  assign ctrl_o          = ctrl_q;
  assign fifo_ctrl_o     = fctrl_q;
  assign irq_tx_wm       = irq_vec[0];
  assign irq_rx_wm       = irq_vec[1];
  assign irq_tx_empty    = irq_vec[2];
  assign irq_rx_overflow = irq_vec[3];
endmodule

// File: rtl/uart_csr_chk.sv
module uart_csr_chk
  import uart_csr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_istate,
  input logic              wr_ienable,
  input logic              wr_itest,
  input logic              wr_status,
  input logic              rd_rdata,
  input logic              rx_valid,
  input logic              rx_en,
  input logic [31:0]       bus_wdata,
  input logic [N_IRQ-1:0]  hw_set,
  input logic [N_IRQ-1:0]  istate_q,
  input logic [N_IRQ-1:0]  irq_vec,
  input logic [CSR_W-1:0]  status_q,
  input logic [BYTE_W-1:0] rdata_q
);
  // R2
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ienable && bus_wdata[N_IRQ-1:0] == '0) |=> (irq_vec == '0));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_istate && hw_set == '0) |=>
      ((istate_q & $past(bus_wdata[N_IRQ-1:0])) == '0));

  // R4
  test_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_itest |=>
      ((istate_q & $past(bus_wdata[N_IRQ-1:0])) == $past(bus_wdata[N_IRQ-1:0])));

  // R5
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((istate_q & $past(hw_set)) == $past(hw_set)));

  // R6
  rx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_en) |=> ($stable(rdata_q) && $stable(status_q)));

  // R7
  rx_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rdata && rx_en && !rx_valid) |=>
      (status_q[ST_RX_IDLE] && status_q[ST_RX_EMPTY]));

  // R8
  status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && !rx_valid) |=> $stable(status_q));
endmodule

bind uart_csr_block uart_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_istate(wr_istate), .wr_ienable(wr_ienable),
  .wr_itest(wr_itest), .wr_status(wr_status), .rd_rdata(rd_rdata),
  .rx_valid(rx_valid), .rx_en(rx_en), .bus_wdata(bus_wdata),
  .hw_set(hw_set), .istate_q(istate_q), .irq_vec(irq_vec),
  .status_q(status_q), .rdata_q(rdata_q)
);

// File: tb/sim_uart_csr_block.sv
module sim_uart_csr_block;
  localparam int ADDR_W  = 10;
  localparam int TXLVL_W = 5;
  localparam int NVEC    = 16;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0]  bus_addr = '0;
  logic [31:0]        bus_wdata = '0, bus_rdata;
  logic [3:0]         hw_set = '0;
  logic               rx_valid = 1'b0;
  logic [7:0]         rx_byte = '0;
  logic [TXLVL_W-1:0] tx_level = '0;
  logic               tx_push;
  logic [7:0]         tx_byte;
  logic [31:0]        ctrl_o, fifo_ctrl_o;
  logic               irq_tx_wm, irq_rx_wm, irq_tx_empty, irq_rx_overflow;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  uart_csr_block #(.ADDR_W(ADDR_W), .TXLVL_W(TXLVL_W)) u0 (.*);

  // {write, addr, wdata, expected read, tag}
  localparam logic [106:0] VECS [NVEC] = '{
    {1'b0, 10'h010, 32'h0, 32'h0000003C, "R1  "},
    {1'b0, 10'h000, 32'h0, 32'h0, "R1  "},
    {1'b0, 10'h00C, 32'h0, 32'h0, "R1  "},
    {1'b1, 10'h008, 32'h5, 32'h0, "R4  "},
    {1'b0, 10'h000, 32'h0, 32'h5, "R4  "},
    {1'b1, 10'h000, 32'h4, 32'h0, "R3  "},
    {1'b0, 10'h000, 32'h0, 32'h1, "R3  "},
    {1'b1, 10'h00C, 32'h2, 32'h0, "R11 "},
    {1'b0, 10'h00C, 32'h0, 32'h2, "R11 "},
    {1'b1, 10'h010, 32'hFF, 32'h0, "R8  "},
    {1'b0, 10'h010, 32'h0, 32'h0000003C, "R8  "},
    {1'b0, 10'h018, 32'h0, 32'h0, "R8  "},
    {1'b0, 10'h3FC, 32'h0, 32'h0, "R9  "},
    {1'b0, 10'h011, 32'h0, 32'h0, "R9  "},
    {1'b1, 10'h01C, 32'hABCD0003, 32'h0, "R11 "},
    {1'b0, 10'h01C, 32'h0, 32'hABCD0003, "R11 "}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input logic [31:0] tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp,
                    input logic [31:0] tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 chk(bus_rdata, exp, tag);
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  task automatic rx_strobe(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  function automatic logic [31:0] irqs();
    return {28'h0, irq_rx_overflow, irq_tx_empty, irq_rx_wm, irq_tx_wm};
  endfunction

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(irqs(), 32'h0, "R1  ");
    chk({31'h0, tx_push}, 32'h0, "R12 ");

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i][106]) wr(VECS[i][105:96], VECS[i][95:64]);
      else rd(VECS[i][105:96], VECS[i][63:32], VECS[i][31:0]);
    end

    // R11: register contents reach the output ports
    @(negedge clk);
    chk(ctrl_o, 32'h2, "R11 ");
    chk(fifo_ctrl_o, 32'hABCD0003, "R11 ");

    // R2: state bit 0 is set; gate it with enable
    wr(10'h004, 32'h1);
    @(negedge clk); chk(irqs(), 32'h1, "R2  ");
    wr(10'h004, 32'h0);
    @(negedge clk); chk(irqs(), 32'h0, "R2  ");
    wr(10'h008, 32'hF);
    wr(10'h004, 32'hF);
    @(negedge clk); chk(irqs(), 32'hF, "R2  ");
    wr(10'h000, 32'hF);
    @(negedge clk); chk(irqs(), 32'h0, "R3  ");

    // R5: hardware set and software clear on the same edge
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 10'h000; bus_wdata = 32'hF;
    hw_set = 4'b1000;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0; hw_set = 4'b0000;
    rd(10'h000, 32'h8, "R5  ");
    @(negedge clk); hw_set = 4'b0010;
    @(posedge clk); #1 hw_set = 4'b0000;
    rd(10'h000, 32'hA, "R5  ");
    wr(10'h000, 32'hF);

    // R6/R7: receive path with RX enabled (control = 2)
    rx_strobe(8'hA5);
    rd(10'h010, 32'h0000000C, "R6  ");
    rd(10'h014, 32'h000000A5, "R6  ");
    rd(10'h010, 32'h0000003C, "R7  ");
    wr(10'h00C, 32'h0);
    rx_strobe(8'h5A);
    rd(10'h014, 32'h000000A5, "R6  ");
    rd(10'h010, 32'h0000003C, "R6  ");
    wr(10'h00C, 32'h2);
    rx_strobe(8'h77);
    wr(10'h00C, 32'h0);
    rd(10'h014, 32'h00000077, "R7  ");
    rd(10'h010, 32'h0000000C, "R7  ");

    // R10
    tx_level = 5'd9;
    rd(10'h020, 32'h9, "R10 ");
    tx_level = 5'd31;
    rd(10'h020, 32'h1F, "R10 ");

    // R12: push strobe during the write cycle
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 10'h018; bus_wdata = 32'h1C3;
    #1;
    chk({31'h0, tx_push}, 32'h1, "R12 ");
    chk({24'h0, tx_byte}, 32'hC3, "R12 ");
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;

    // R9: misaligned write leaves control alone
    wr(10'h00D, 32'hFFFF_FFFF);
    rd(10'h00C, 32'h0, "R9  ");
    wr(10'h3F0, 32'hFFFF_FFFF);
    rd(10'h00C, 32'h0, "R9  ");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule